// File: doc/BRIEF.md
# Standby Power-Mode Controller

This block decides when a chip may drop into its deepest low-power state and brings it back out safely. It watches a one-cycle sleep strobe from the processor together with a software-written standby-enable bit. When the strobe arrives with standby enabled and the watchdog stopped, the controller does four things. It stops the processor clock, the peripheral clocks and both external clock outputs. It drives the two status pins to the standby code. It gives a one-cycle reset pulse to a chosen subset of peripheral modules. The processor and cache keep their contents because only their clock is stopped. Any other sleep strobe gives a light sleep, in which only the processor clock stops.

A wake event ends standby, but the clocks do not return at once. The watchdog's up-counter is reused as an oscillator-settling timer. Software clears the counter beforehand and selects a prescaler, so it runs from 0 up to overflow. Each counter step takes 2^(sel+1) input cycles. On overflow the clocks come back, the status pins return to 00 and the standby-enable bit clears itself.

Top module: `stby_ctrl`

## Requirements
- R1: After reset, all clock enables are 1, the status pins read 00 and every module reset output is high (inactive).
- R2: A sleep strobe that arrives with standby enabled (address 0, bit 0 = 1) and the watchdog stopped (address 1, bit 0 = 0) enters standby one cycle later. In standby the processor, peripheral and both external clock enables are 0 and the status pins read 01 (status[1]=0, status[0]=1).
- R3: A sleep strobe with standby disabled gives light sleep: the processor clock enable is 0, the peripheral and external enables stay 1, and the status pins read 00.
- R4: A sleep strobe while the watchdog is running (address 1, bit 0 = 1) gives light sleep even when standby is enabled.
- R5: On standby entry, each module whose bit in RESET_MASK is 1 (by default outputs 0 to 6) sees its reset output low for exactly one cycle. Outputs whose mask bit is 0 (by default 7 to 13) never go low.
- R6: A wake event during light sleep restores the processor clock enable on the next cycle.
- R7: A wake event during standby keeps every clock off and the status at 01 for exactly (2^CNT_W − start count) × 2^(sel+1) cycles. Here sel is address 1, bits 3:1. After that the run state returns. With a start count of 0 and the default width, sel 0 gives 512 cycles and sel 2 gives 2048 cycles.
- R8: Wake and sleep strobes that arrive during the settling count are ignored and do not change its length.
- R9: Once settling completes, the standby-enable bit reads as cleared, so a later sleep strobe with no new write gives light sleep.
- R10: The counter value written at address 2 is the start point of the settling count. A start value of 0xF0 with sel 0 gives 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 power control, 1 watchdog control, 2 watchdog counter |
| wrData | input | 8 | Register write data |
| sleepReq | input | 1 | One-cycle sleep strobe from the processor |
| wake | input | 1 | Wake event (interrupt or reset request) |
| cpuClkEn | output | 1 | Processor and cache clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| extClkEn | output | 2 | Enables for the two external clock output pins |
| status | output | 2 | Status pins, standby code 01 |
| modRstN | output | 14 | Per-module active-low reset pulses |

## Verification
A wrong mode decision shows at the ports on the cycle after the sleep strobe, as the wrong clock-enable pattern or status code. A wrong prescaler tap or counter start shows only when settling ends: the clocks return early or late, and the error is a whole multiple of 2^(sel+1) cycles. Exact cycle counts are therefore needed to expose it. A reset pulse on the wrong group or of the wrong length shows on modRstN in the entry cycle and the cycle after it.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_STANDBY = 2'd2,
    ST_SETTLE  = 2'd3
  } pwrState_e;

  typedef struct packed {
    logic clearPre;
    logic countEn;
    logic clearStby;
  } dpCtrl_t;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_PWRCTL = 2'd0;
  localparam logic [ADDR_W-1:0] A_WDTCTL = 2'd1;
  localparam logic [ADDR_W-1:0] A_WDTCNT = 2'd2;

  localparam logic [1:0] STAT_RUN     = 2'b00;
  localparam logic [1:0] STAT_STANDBY = 2'b01;
endpackage

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dpCtrl_t           ctl,
  output logic              standbyEn,
  output logic              wdtRun,
  output logic              overflow
);
  localparam int PRE_W = 1 << SEL_W;

  logic [SEL_W-1:0] clkSel;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   tapWide;
  logic [PRE_W-1:0] tapMask;
  logic             tick;

  always_comb begin
    tapWide = ((PRE_W+1)'(1) << (32'(clkSel) + 1)) - (PRE_W+1)'(1);
    tapMask = tapWide[PRE_W-1:0];
    tick    = &(pre | ~tapMask);
    overflow = ctl.countEn && tick && (&cnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      standbyEn <= 1'b0;
    end else if (ctl.clearStby) begin
      standbyEn <= 1'b0;
    end else if (wrEn && wrAddr == A_PWRCTL) begin
      standbyEn <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtRun <= 1'b0;
      clkSel <= '0;
    end else if (wrEn && wrAddr == A_WDTCTL) begin
      wdtRun <= wrData[0];
      clkSel <= wrData[SEL_W:1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre <= '0;
    end else if (ctl.clearPre) begin
      pre <= '0;
    end else if (ctl.countEn) begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.countEn) begin
      if (tick) cnt <= cnt + 1'b1;
    end else if (wrEn && wrAddr == A_WDTCNT) begin
      cnt <= wrData[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int               NUM_MODS   = 14,
  parameter logic [NUM_MODS-1:0] RESET_MASK = 14'h007F
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepReq,
  input  logic                wake,
  input  logic                standbyEn,
  input  logic                wdtRun,
  input  logic                overflow,
  output dpCtrl_t             ctl,
  output logic                cpuClkEn,
  output logic                periphClkEn,
  output logic [1:0]          extClkEn,
  output logic [1:0]          status,
  output logic [NUM_MODS-1:0] modRstN
);
  pwrState_e state, nextState;
  logic      enterStby;

  always_comb begin
    nextState = state;
    enterStby = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (sleepReq) begin
          if (standbyEn && !wdtRun) begin
            nextState = ST_STANDBY;
            enterStby = 1'b1;
          end else begin
            nextState = ST_SLEEP;
          end
        end
      end
      ST_SLEEP:   if (wake) nextState = ST_RUN;
      ST_STANDBY: if (wake) nextState = ST_SETTLE;
      ST_SETTLE:  if (overflow) nextState = ST_RUN;
      default:    nextState = ST_RUN;
    endcase
  end

  always_comb begin
    ctl.clearPre  = enterStby;
    ctl.countEn   = (state == ST_SETTLE);
    ctl.clearStby = (state == ST_SETTLE) && overflow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      modRstN <= '1;
    end else begin
      state   <= nextState;
      modRstN <= enterStby ? ~RESET_MASK : '1;
    end
  end

  always_comb begin
    cpuClkEn    = (state == ST_RUN);
    periphClkEn = (state == ST_RUN) || (state == ST_SLEEP);
    extClkEn    = {2{periphClkEn}};
    status      = (state == ST_STANDBY || state == ST_SETTLE) ? STAT_STANDBY : STAT_RUN;
  end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int SEL_W    = 3,
  parameter int NUM_MODS = 14,
  parameter logic [NUM_MODS-1:0] RESET_MASK = 14'h007F
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                sleepReq,
  input  logic                wake,
  output logic                cpuClkEn,
  output logic                periphClkEn,
  output logic [1:0]          extClkEn,
  output logic [1:0]          status,
  output logic [NUM_MODS-1:0] modRstN
);
  dpCtrl_t ctl;
  logic    standbyEn;
  logic    wdtRun;
  logic    overflow;

  stby_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctl(ctl), .standbyEn(standbyEn), .wdtRun(wdtRun), .overflow(overflow)
  );

  stby_fsm #(.NUM_MODS(NUM_MODS), .RESET_MASK(RESET_MASK)) u_fsm (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wake(wake),
    .standbyEn(standbyEn), .wdtRun(wdtRun), .overflow(overflow),
    .ctl(ctl), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .extClkEn(extClkEn), .status(status), .modRstN(modRstN)
  );
endmodule

// File: rtl/stby_ctrl_checker.sv
module stby_ctrl_checker #(
  parameter int NUM_MODS = 14,
  parameter logic [NUM_MODS-1:0] RESET_MASK = 14'h007F
) (
  input logic                clk,
  input logic                rstN,
  input logic                wake,
  input logic                cpuClkEn,
  input logic                periphClkEn,
  input logic [1:0]          extClkEn,
  input logic [1:0]          status,
  input logic [NUM_MODS-1:0] modRstN
);
  p_standby_gates_r2: assert property (@(posedge clk) disable iff (!rstN)
    status == 2'b01 |-> (!cpuClkEn && !periphClkEn && extClkEn == 2'b00));

  p_sleep_status_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && periphClkEn) |-> status == 2'b00);

  p_rst_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modRstN != '1) |=> (modRstN == '1));

  p_retain_group_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((modRstN | RESET_MASK) == '1));

  p_wake_sleep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && periphClkEn && wake) |=> cpuClkEn);

  p_exit_to_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[0]) |-> (cpuClkEn && periphClkEn));
endmodule

bind stby_ctrl stby_ctrl_checker #(.NUM_MODS(NUM_MODS), .RESET_MASK(RESET_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .wake(wake), .cpuClkEn(cpuClkEn),
  .periphClkEn(periphClkEn), .extClkEn(extClkEn), .status(status), .modRstN(modRstN)
);

// File: tb/stby_ctrl_bench.sv
`timescale 1ns/1ps
module stby_ctrl_bench;
  localparam int W = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        sleepReq = 1'b0;
  logic        wake = 1'b0;
  logic        cpuClkEn, periphClkEn;
  logic [1:0]  extClkEn, status;
  logic [13:0] modRstN;

  int tests = 0;
  int fails = 0;

  typedef struct { string name; logic [W-1:0] exp; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  stby_ctrl u_stby_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sleepReq(sleepReq), .wake(wake), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .extClkEn(extClkEn), .status(status),
    .modRstN(modRstN)
  );

  function automatic logic [W-1:0] mk(logic c, logic p, logic [1:0] e,
                                      logic [1:0] s, logic [13:0] r);
    return {c, p, e, s, r};
  endfunction

  localparam logic [13:0] ALL1  = 14'h3FFF;
  localparam logic [13:0] PULSE = 14'h3F80;

  // monitor: pops expectations shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it  = sb.pop_front();
      act = {cpuClkEn, periphClkEn, extClkEn, status, modRstN};
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.name, act, it.exp);
      end
    end
  end

  task automatic expectNow(string name, logic [W-1:0] exp);
    item_t it;
    it.name = name;
    it.exp  = exp;
    sb.push_back(it);
  endtask

  task automatic checkCount(string name, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", name, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseSleep();
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
  endtask

  task automatic pulseWake();
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  // wake from standby, count cycles until processor clock returns
  task automatic settle(output int n, input bit disturb);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    n = 0;
    while (!cpuClkEn && n < 10000) begin
      n++;
      if (disturb && n == 100) wake = 1'b1;
      if (disturb && n == 101) wake = 1'b0;
      if (disturb && n == 200) sleepReq = 1'b1;
      if (disturb && n == 201) sleepReq = 1'b0;
      if (disturb && n == 150) expectNow("R8 still settling", mk(0, 0, 2'b00, 2'b01, ALL1));
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [W-1:0] RUNW   = mk(1, 1, 2'b11, 2'b00, ALL1);
  localparam logic [W-1:0] SLEEPW = mk(0, 1, 2'b11, 2'b00, ALL1);
  localparam logic [W-1:0] STBYW  = mk(0, 0, 2'b00, 2'b01, ALL1);

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectNow("R1 reset state", RUNW);
    @(negedge clk);

    // R3: standby disabled -> light sleep
    regWrite(2'd0, 8'h00);
    pulseSleep();
    expectNow("R3 light sleep", SLEEPW);
    @(negedge clk);
    pulseWake();
    expectNow("R6 wake from light sleep", RUNW);
    @(negedge clk);

    // R4: watchdog running blocks standby
    regWrite(2'd0, 8'h01);
    regWrite(2'd1, 8'h01);
    pulseSleep();
    expectNow("R4 watchdog running gives light sleep", SLEEPW);
    @(negedge clk);
    pulseWake();
    expectNow("R6 wake again", RUNW);
    @(negedge clk);

    // R2/R5/R7: standby, sel 0, count from 0
    regWrite(2'd1, 8'h00);
    regWrite(2'd2, 8'h00);
    pulseSleep();
    expectNow("R2 R5 standby entry with reset pulse", mk(0, 0, 2'b00, 2'b01, PULSE));
    @(negedge clk);
    expectNow("R5 reset pulse ends after one cycle", STBYW);
    repeat (5) @(negedge clk);
    expectNow("R2 standby held without wake", STBYW);
    @(negedge clk);
    settle(n, 1'b0);
    checkCount("R7 settle sel0", n, 512);
    expectNow("R7 run after settle", RUNW);
    @(negedge clk);

    // R9: enable bit cleared by wake completion
    pulseSleep();
    expectNow("R9 no standby without rewrite", SLEEPW);
    @(negedge clk);
    pulseWake();

    // R7 sel 2
    regWrite(2'd0, 8'h01);
    regWrite(2'd1, 8'h04);
    regWrite(2'd2, 8'h00);
    pulseSleep();
    expectNow("R2 standby sel2", mk(0, 0, 2'b00, 2'b01, PULSE));
    @(negedge clk);
    settle(n, 1'b0);
    checkCount("R7 settle sel2", n, 2048);

    // R8: strobes during settling ignored
    regWrite(2'd0, 8'h01);
    regWrite(2'd1, 8'h00);
    regWrite(2'd2, 8'h00);
    pulseSleep();
    @(negedge clk);
    settle(n, 1'b1);
    checkCount("R8 settle with strobes", n, 512);
    expectNow("R8 run after disturbed settle", RUNW);
    @(negedge clk);

    // R10: preset counter
    regWrite(2'd0, 8'h01);
    regWrite(2'd2, 8'hF0);
    pulseSleep();
    @(negedge clk);
    settle(n, 1'b0);
    checkCount("R10 settle from 0xF0", n, 32);
    expectNow("R10 run after short settle", RUNW);
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule